// File: doc/BRIEF.md
# Self-Routing Omega Switch Fabric

This block is a pipelined multistage interconnect with `N_PORTS` inputs and `N_PORTS` outputs, where `N_PORTS` is a power of two. It is built from log2(`N_PORTS`) columns of two-by-two switching elements, with `N_PORTS/2` elements in each column. Each input offers a packet: a valid flag, a destination port number and a payload. A fixed perfect-shuffle wiring sits in front of every column. It moves the packet at port address `a` to the address `a` rotated left by one bit. Each element then sets itself to pass its two inputs straight through or to exchange them. The setting follows one bit of each packet's destination. Column 0 uses the most significant destination bit and the last column uses the least significant. A bit value of 0 selects the upper (even) output of the element and a value of 1 selects the lower (odd) output.

No central controller exists. Routing comes entirely from the destination carried with each packet. When both packets at an element ask for the same output, the element keeps one of them by a round-robin rule and discards the other. The fabric then raises a one-cycle blocked flag for the input that sent the discarded packet. Each column is registered, so a new set of packets can enter on every cycle. Each surviving packet leaves on the output port that equals its destination, together with its payload and the number of the input it came from.

Top module: `omega_fabric`

## Requirements
- R1: A packet that is presented with `in_valid` high and is never discarded appears with `out_valid` high exactly log2(`N_PORTS`) clock cycles later. It appears once, on exactly one output port.
- R2: Every packet that reaches the outputs leaves on the port whose index equals its `in_dest` value. `out_data` carries its unchanged `in_data` and `out_src` carries the index of the input it entered on.
- R3: When the two valid packets at one element want the same output, exactly one of them continues and the other is removed from the fabric. Each valid packet entering a column therefore either leaves that column or is discarded there, never both.
- R4: Each element holds a one-bit preference. It is reset to favour the upper input, which is the even shuffled position. A conflict is won by the favoured input, and after every conflict the preference swaps to the other input.
- R5: A packet discarded in column k (k = 0 for the first column) raises `blocked[src]` for exactly one cycle. The cycle is k+1 cycles after the packet was presented, where src is its input index. `blocked` is low for an input in every other cycle.
- R6: While `rst` is high and in the cycle after it is released, all `out_valid` and `blocked` bits are 0.
- R7: An input with `in_valid` low injects nothing, whatever its `in_dest` and `in_data`. It never causes a conflict, so it leaves every element's round-robin preference unchanged.
- R8: The fabric accepts a full set of packets on every cycle with no bubbles. Back-to-back sets follow R1 to R5 independently of one another, except for the shared round-robin preferences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_PORTS | One valid bit per input |
| in_dest | input | N_PORTS x log2(N_PORTS) | Destination port number per input |
| in_data | input | N_PORTS x DATA_W | Payload per input |
| out_valid | output | N_PORTS | One valid bit per output port |
| out_data | output | N_PORTS x DATA_W | Payload delivered on each output port |
| out_src | output | N_PORTS x log2(N_PORTS) | Input index the delivered packet came from |
| blocked | output | N_PORTS | Per-input flag: a packet from this input was discarded |

## Verification
The bench builds the fabric with eight ports and an eight-bit payload. This gives three columns of four elements each, so a discarded packet can be flagged at three different delays and every element sees conflicts from several input pairs. The random traffic phase mixes partial and full loads. This lets the round-robin preferences of all twelve elements drift into unrelated states while several sets of packets are in flight at once. Directed phases cover the reset preference, a repeated conflict on one element, a conflict pattern carried only by idle inputs, and a full eight-way collision on a single destination.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Setting of one two-by-two element
    typedef enum logic {
        SET_STRAIGHT = 1'b0,
        SET_EXCHANGE = 1'b1
    } xset_e;

    // Perfect-shuffle wiring: rotate a port address left by one bit
    function automatic int rotl_idx(input int idx, input int bits);
        int mask;
        mask = (1 << bits) - 1;
        return ((idx << 1) | (idx >> (bits - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_elem.sv
module omega_elem
    import omega_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 8,
    parameter int STEER  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             in_vld,
    input  logic [1:0][TAG_W-1:0]  in_tag,
    input  logic [1:0][TAG_W-1:0]  in_src,
    input  logic [1:0][DATA_W-1:0] in_dat,
    output logic [1:0]             out_vld,
    output logic [1:0][TAG_W-1:0]  out_tag,
    output logic [1:0][TAG_W-1:0]  out_src,
    output logic [1:0][DATA_W-1:0] out_dat,
    output logic [1:0]             out_drop
);

    typedef struct packed {
        logic prio;   // 0: upper input favoured, 1: lower input favoured
    } elem_st_t;

    elem_st_t st_d, st_q;
    logic [1:0] want;
    logic [1:0] keep;
    logic       clash;
    xset_e      setting;

    always_comb begin
        want     = {in_tag[1][STEER], in_tag[0][STEER]};
        clash    = in_vld[0] && in_vld[1] && (want[0] == want[1]);
        keep[0]  = in_vld[0] && !(clash && st_q.prio);
        keep[1]  = in_vld[1] && !(clash && !st_q.prio);
        out_drop = in_vld & ~keep;

        if (keep[0]) begin
            setting = want[0] ? SET_EXCHANGE : SET_STRAIGHT;
        end else begin
            setting = want[1] ? SET_STRAIGHT : SET_EXCHANGE;
        end

        if (setting == SET_STRAIGHT) begin
            out_vld = keep;
            out_tag = in_tag;
            out_src = in_src;
            out_dat = in_dat;
        end else begin
            out_vld = {keep[0], keep[1]};
            out_tag = {in_tag[0], in_tag[1]};
            out_src = {in_src[0], in_src[1]};
            out_dat = {in_dat[0], in_dat[1]};
        end

        st_d = st_q;
        if (clash) begin
            st_d.prio = ~st_q.prio;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    rr_flip_chk: assert property (@(posedge clk) disable iff (rst)
        clash |=> (st_q.prio != $past(st_q.prio)));

    // R4
    rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clash |=> $stable(st_q.prio));

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int TAG_W   = 3,
    parameter int DATA_W  = 8,
    parameter int STAGE   = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_PORTS-1:0]             in_vld,
    input  logic [N_PORTS-1:0][TAG_W-1:0]  in_tag,
    input  logic [N_PORTS-1:0][TAG_W-1:0]  in_src,
    input  logic [N_PORTS-1:0][DATA_W-1:0] in_dat,
    output logic [N_PORTS-1:0]             out_vld,
    output logic [N_PORTS-1:0][TAG_W-1:0]  out_tag,
    output logic [N_PORTS-1:0][TAG_W-1:0]  out_src,
    output logic [N_PORTS-1:0][DATA_W-1:0] out_dat,
    output logic [N_PORTS-1:0]             out_drop
);

    localparam int N_ELEM = N_PORTS / 2;
    localparam int STEER  = TAG_W - 1 - STAGE;
    localparam int KEEP   = STAGE + 1;

    typedef struct packed {
        logic [N_PORTS-1:0]             vld;
        logic [N_PORTS-1:0][TAG_W-1:0]  tag;
        logic [N_PORTS-1:0][TAG_W-1:0]  src;
        logic [N_PORTS-1:0][DATA_W-1:0] dat;
        logic [N_PORTS-1:0]             drop;  // indexed by source input
    } stg_st_t;

    stg_st_t st_d, st_q;

    logic [N_PORTS-1:0]             sh_vld;
    logic [N_PORTS-1:0][TAG_W-1:0]  sh_tag;
    logic [N_PORTS-1:0][TAG_W-1:0]  sh_src;
    logic [N_PORTS-1:0][DATA_W-1:0] sh_dat;

    logic [N_PORTS-1:0]             el_vld;
    logic [N_PORTS-1:0][TAG_W-1:0]  el_tag;
    logic [N_PORTS-1:0][TAG_W-1:0]  el_src;
    logic [N_PORTS-1:0][DATA_W-1:0] el_dat;
    logic [N_PORTS-1:0]             el_drop;  // indexed by shuffled position

    // Shuffle wiring in front of the column
    always_comb begin
        sh_vld = '0;
        sh_tag = '0;
        sh_src = '0;
        sh_dat = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            sh_vld[rotl_idx(p, TAG_W)] = in_vld[p];
            sh_tag[rotl_idx(p, TAG_W)] = in_tag[p];
            sh_src[rotl_idx(p, TAG_W)] = in_src[p];
            sh_dat[rotl_idx(p, TAG_W)] = in_dat[p];
        end
    end

    for (genvar j = 0; j < N_ELEM; j++) begin : g_elem
        omega_elem #(
            .TAG_W (TAG_W),
            .DATA_W(DATA_W),
            .STEER (STEER)
        ) u_elem (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (sh_vld[2*j+1:2*j]),
            .in_tag  (sh_tag[2*j+1:2*j]),
            .in_src  (sh_src[2*j+1:2*j]),
            .in_dat  (sh_dat[2*j+1:2*j]),
            .out_vld (el_vld[2*j+1:2*j]),
            .out_tag (el_tag[2*j+1:2*j]),
            .out_src (el_src[2*j+1:2*j]),
            .out_dat (el_dat[2*j+1:2*j]),
            .out_drop(el_drop[2*j+1:2*j])
        );
    end

    always_comb begin
        st_d.vld  = el_vld;
        st_d.tag  = el_tag;
        st_d.src  = el_src;
        st_d.dat  = el_dat;
        st_d.drop = '0;
        for (int q = 0; q < N_PORTS; q++) begin
            if (el_drop[q]) begin
                st_d.drop[sh_src[q]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_tag  = st_q.tag;
    assign out_src  = st_q.src;
    assign out_dat  = st_q.dat;
    assign out_drop = st_q.drop;

    // R3
    keep_or_drop_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($countones(st_q.vld) + $countones(st_q.drop)) == $past($countones(in_vld))));

    for (genvar p = 0; p < N_PORTS; p++) begin : g_place
        // R2
        place_chk: assert property (@(posedge clk) disable iff (rst)
            st_q.vld[p] |-> ((st_q.tag[p] >> (TAG_W - KEEP)) == TAG_W'(p % (1 << KEEP))));
    end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
    parameter int  N_PORTS = 8,
    parameter int  DATA_W  = 8,
    localparam int TAG_W   = $clog2(N_PORTS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N_PORTS-1:0]               in_valid,
    input  logic [N_PORTS-1:0][TAG_W-1:0]    in_dest,
    input  logic [N_PORTS-1:0][DATA_W-1:0]   in_data,
    output logic [N_PORTS-1:0]               out_valid,
    output logic [N_PORTS-1:0][DATA_W-1:0]   out_data,
    output logic [N_PORTS-1:0][TAG_W-1:0]    out_src,
    output logic [N_PORTS-1:0]               blocked
);

    localparam int NUM_STG = TAG_W;

    logic [NUM_STG:0][N_PORTS-1:0]             ch_vld;
    logic [NUM_STG:0][N_PORTS-1:0][TAG_W-1:0]  ch_tag;
    logic [NUM_STG:0][N_PORTS-1:0][TAG_W-1:0]  ch_src;
    logic [NUM_STG:0][N_PORTS-1:0][DATA_W-1:0] ch_dat;
    logic [NUM_STG-1:0][N_PORTS-1:0]           stg_drop;

    assign ch_vld[0] = in_valid;
    assign ch_tag[0] = in_dest;
    assign ch_dat[0] = in_data;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_srcid
        assign ch_src[0][p] = TAG_W'(p);
    end

    for (genvar s = 0; s < NUM_STG; s++) begin : g_stage
        omega_stage #(
            .N_PORTS(N_PORTS),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .STAGE  (s)
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (ch_vld[s]),
            .in_tag  (ch_tag[s]),
            .in_src  (ch_src[s]),
            .in_dat  (ch_dat[s]),
            .out_vld (ch_vld[s+1]),
            .out_tag (ch_tag[s+1]),
            .out_src (ch_src[s+1]),
            .out_dat (ch_dat[s+1]),
            .out_drop(stg_drop[s])
        );
    end

    always_comb begin
        blocked = '0;
        for (int s = 0; s < NUM_STG; s++) begin
            blocked = blocked | stg_drop[s];
        end
    end

    assign out_valid = ch_vld[NUM_STG];
    assign out_data  = ch_dat[NUM_STG];
    assign out_src   = ch_src[NUM_STG];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_dest
        // R2
        dest_match_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid[p] |-> (ch_tag[NUM_STG][p] == TAG_W'(p)));
    end

endmodule

// File: tb/omega_fabric_bench.sv
module omega_fabric_bench;

    localparam int NP    = 8;
    localparam int DW    = 8;
    localparam int TW    = 3;
    localparam int NS    = 3;
    localparam int SLOTS = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NP-1:0]         in_valid;
    logic [NP-1:0][TW-1:0] in_dest;
    logic [NP-1:0][DW-1:0] in_data;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0][DW-1:0] out_data;
    logic [NP-1:0][TW-1:0] out_src;
    logic [NP-1:0]         blocked;

    omega_fabric #(.N_PORTS(NP), .DATA_W(DW)) u_omega_fabric (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_dest  (in_dest),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_src  (out_src),
        .blocked  (blocked)
    );

    // Reference schedule, indexed by slot (posedge count after reset release)
    logic [NP-1:0]         ev [SLOTS];
    logic [NP-1:0][DW-1:0] ed [SLOTS];
    logic [NP-1:0][TW-1:0] es [SLOTS];
    logic [NP-1:0]         eb [SLOTS];
    int ptr [NS][NP/2];

    int checks = 0;
    int errors = 0;
    int slot   = 0;
    bit done   = 1'b0;

    // Behavioural model of one wave entering at edge e1
    task automatic model_wave(input int e1);
        int  pos [NP];
        bit  alive [NP];
        for (int p = 0; p < NP; p++) begin
            alive[p] = in_valid[p];
            pos[p]   = p;
        end
        for (int k = 0; k < NS; k++) begin
            for (int p = 0; p < NP; p++) begin
                if (alive[p]) pos[p] = ((pos[p] << 1) | (pos[p] >> (NS - 1))) & (NP - 1);
            end
            for (int j = 0; j < NP/2; j++) begin
                int up = -1;
                int lo = -1;
                for (int p = 0; p < NP; p++) begin
                    if (alive[p] && (pos[p] >> 1) == j) begin
                        if (pos[p] % 2 == 1) lo = p; else up = p;
                    end
                end
                if (up >= 0 && lo >= 0 && in_dest[up][NS-1-k] == in_dest[lo][NS-1-k]) begin
                    int loser = (ptr[k][j] == 0) ? lo : up;
                    alive[loser] = 1'b0;
                    eb[(e1 + k) % SLOTS][loser] = 1'b1;
                    ptr[k][j] = 1 - ptr[k][j];
                end
                if (up >= 0 && alive[up]) pos[up] = (j << 1) | int'(in_dest[up][NS-1-k]);
                if (lo >= 0 && alive[lo]) pos[lo] = (j << 1) | int'(in_dest[lo][NS-1-k]);
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (alive[p]) begin
                ev[(e1 + NS - 1) % SLOTS][pos[p]] = 1'b1;
                ed[(e1 + NS - 1) % SLOTS][pos[p]] = in_data[p];
                es[(e1 + NS - 1) % SLOTS][pos[p]] = TW'(p);
            end
        end
    endtask

    task automatic compare(input int s, input string lbl);
        int k = s % SLOTS;
        for (int p = 0; p < NP; p++) begin
            checks++;
            if (out_valid[p] !== ev[k][p] ||
                (ev[k][p] && (out_data[p] !== ed[k][p] || out_src[p] !== es[k][p]))) begin
                errors++;
                $display("FAIL R1 R2 [%s] slot %0d port %0d: actual v=%0b d=%h src=%0d expected v=%0b d=%h src=%0d",
                         lbl, s, p, out_valid[p], out_data[p], out_src[p], ev[k][p], ed[k][p], es[k][p]);
            end
        end
        checks++;
        if (blocked !== eb[k]) begin
            errors++;
            $display("FAIL R5 [%s] slot %0d: actual blocked=%b expected=%b", lbl, s, blocked, eb[k]);
        end
        ev[k] = '0;
        eb[k] = '0;
    endtask

    task automatic step(input string lbl);
        model_wave(slot + 1);
        @(posedge clk);
        slot++;
        @(negedge clk);
        compare(slot, lbl);
    endtask

    task automatic idle_inputs();
        in_valid = '0;
        in_dest  = '0;
        in_data  = '0;
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) begin
            ev[i] = '0; ed[i] = '0; es[i] = '0; eb[i] = '0;
        end
        for (int k = 0; k < NS; k++)
            for (int j = 0; j < NP/2; j++) ptr[k][j] = 0;
        idle_inputs();

        // R6: outputs quiet during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== '0 || blocked !== '0) begin
                errors++;
                $display("FAIL R6 reset: actual valid=%b blocked=%b expected 0 0", out_valid, blocked);
            end
        end
        rst = 1'b0;

        // R4: repeated conflict at one element (inputs 0 and 4 both to port 0)
        for (int c = 0; c < 4; c++) begin
            idle_inputs();
            in_valid[0] = 1'b1; in_dest[0] = 3'd0; in_data[0] = DW'(8'h10 + c);
            in_valid[4] = 1'b1; in_dest[4] = 3'd0; in_data[4] = DW'(8'h40 + c);
            step("R4 rr");
        end

        // R7: idle inputs carrying a conflict pattern, then a real conflict
        for (int c = 0; c < 3; c++) begin
            in_valid = '0;
            for (int p = 0; p < NP; p++) begin
                in_dest[p] = 3'd0;
                in_data[p] = 8'hEE;
            end
            step("R7 idle");
        end
        idle_inputs();
        in_valid[0] = 1'b1; in_dest[0] = 3'd0; in_data[0] = 8'hA0;
        in_valid[4] = 1'b1; in_dest[4] = 3'd0; in_data[4] = 8'hA4;
        step("R7 after idle");

        // R1: lone packets with gaps
        for (int c = 0; c < 16; c++) begin
            idle_inputs();
            if (c % 2 == 0) begin
                in_valid[(c/2) % NP] = 1'b1;
                in_dest[(c/2) % NP]  = TW'((c * 3 + 1) % NP);
                in_data[(c/2) % NP]  = DW'(8'h80 + c);
            end
            step("R1 single");
        end

        // R2 / R8: cyclic shift permutations back to back
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < NP; p++) begin
                in_valid[p] = 1'b1;
                in_dest[p]  = TW'((p + c) % NP);
                in_data[p]  = DW'(c * 16 + p);
            end
            step("R2 R8 shift");
        end

        // R3: every input to port 5
        for (int c = 0; c < 6; c++) begin
            for (int p = 0; p < NP; p++) begin
                in_valid[p] = 1'b1;
                in_dest[p]  = 3'd5;
                in_data[p]  = DW'(8'hC0 + c * 8 + p);
            end
            step("R3 collide");
        end

        // R5: random traffic
        for (int c = 0; c < 150; c++) begin
            for (int p = 0; p < NP; p++) begin
                in_valid[p] = 1'($urandom);
                in_dest[p]  = TW'($urandom);
                in_data[p]  = DW'($urandom);
            end
            step("R5 random");
        end

        // R8: drain
        idle_inputs();
        for (int c = 0; c < NS + 2; c++) step("R8 drain");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule